// File: doc/BRIEF.md
# Crossbar Doorbell Mailbox for Multiple Cores

This block lets each of N cores (default 4) signal every other core through a private mailbox channel. Each ordered pair of cores (sender, target) has one channel. A channel holds a 31-bit message, a 30-bit extension word, a busy flag and a done flag. The sender first writes the extension and then the message with bit 31 set. The channel then turns busy, and the target sees the message and extension in its incoming registers for that sender. The target acknowledges by writing bit 31 back to its incoming message register. That write clears busy on both sides and raises the sender's done flag. The sender clears done by writing 1 to it.

A single register port reaches every bank. A core index selects the bank and a 7-bit byte offset selects the register inside it. Writes take effect at the clock edge, and read data appears one cycle after the read strobe. Each core has its own level interrupt. It combines new-message events and done events, each gated by a per-peer enable bit in that core's control register.

Top module: `mbx_xbar`

## Requirements
- R1: In bank c, the registers for peer p sit at byte offset 16·p: +0x0 incoming message, +0x4 incoming extension, +0x8 outgoing message, +0xC outgoing extension. The control register is at 0x50. Any other offset reads 0 and ignores writes.
- R2: A write to the outgoing message register for peer p with bit 31 = 1, while the channel is idle, sets busy and stores bits 30:0. Both the sender's outgoing message and the target's incoming message register for that sender then read {1, payload}.
- R3: A write to the outgoing extension register stores bits 29:0 only while the channel is idle. The target's incoming extension register for that sender reads {2'b00, payload}. The outgoing extension register reads {1'b0, done, payload}.
- R4: A write to an outgoing message register while its channel is busy, or a write with bit 31 = 0, leaves busy and payload unchanged.
- R5: A write with bit 31 = 1 to the target's incoming message register, while the channel is busy, clears busy on both sides, keeps the payload, and sets the sender's done flag (bit 30 of its outgoing extension). A write with bit 31 = 0 has no effect.
- R6: Writing bit 30 = 1 to the outgoing extension register clears the done flag.
- R7: A bank's slot for its own core index always reads 0 and ignores writes.
- R8: In the control register, bit j enables the new-message interrupt from peer j and bit 8+j enables the done interrupt for peer j. Bits for the core itself and unused bits read 0.
- R9: irq[c] is high exactly while some peer j has a busy channel j→c with busy enable j set, or a done channel c→j with done enable 8+j set.
- R10: bus_rdata shows the selected register one cycle after bus_rd and is 0 in the cycle after no read.
- R11: Reset clears all busy and done flags, payloads and enables, and holds every irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_core | input | $clog2(N) | Bank (core) selected by the access |
| bus_addr | input | 7 | Byte offset inside the bank |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| irq | output | N | Level interrupt per core |

## Verification
The assertions check the channel state on every cycle. They cover the send that sets busy, the ignored overwrite of a busy channel, the acknowledge that moves busy to done, and the done clear. They also check that no self channel ever turns busy or done, that irq never rises without a pending flag, and that read data is zero after an idle cycle. Only the bench's scenarios can show the rest. That covers the address map, the visibility of the payload and extension on both sides, the enable gating of each interrupt source, the masking of self bits in the control register, and the clearing of all state by a mid-run reset.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MSG_W       = 31;
    localparam int EXT_W       = 30;
    localparam int DATA_W      = 32;
    localparam int OFS_W       = 7;
    localparam int DONE_EN_LSB = 8;
    localparam logic [OFS_W-1:0] CTL_OFS = 7'h50;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IN_MSG,
        ACC_IN_EXT,
        ACC_OUT_MSG,
        ACC_OUT_EXT,
        ACC_CTL
    } acc_e;
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int N = 4,
    localparam int CORE_W = $clog2(N)
) (
    input  logic [OFS_W-1:0]  addr,
    output acc_e              kind,
    output logic [CORE_W-1:0] peer
);
    localparam logic [2:0] N_L = 3'(N);

    always_comb begin
        kind = ACC_NONE;
        peer = addr[4 +: CORE_W];
        if (addr == CTL_OFS) begin
            kind = ACC_CTL;
        end else if (addr[1:0] == 2'b00 && addr[6:4] < N_L) begin
            unique case (addr[3:2])
                2'd0: kind = ACC_IN_MSG;
                2'd1: kind = ACC_IN_EXT;
                2'd2: kind = ACC_OUT_MSG;
                default: kind = ACC_OUT_EXT;
            endcase
        end
    end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int N = 4
) (
    input  logic [N-1:0][N-1:0] busy,     // [sender][target]
    input  logic [N-1:0][N-1:0] done,     // [sender][target]
    input  logic [N-1:0][N-1:0] en_busy,  // [core][peer]
    input  logic [N-1:0][N-1:0] en_done,  // [core][peer]
    output logic [N-1:0]        irq
);
    for (genvar c = 0; c < N; c++) begin : g_core
        always_comb begin
            irq[c] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != c) begin
                    irq[c] = irq[c]
                           | (busy[j][c] & en_busy[c][j])
                           | (done[c][j] & en_done[c][j]);
                end
            end
        end
    end
endmodule

// File: rtl/mbx_xbar.sv
module mbx_xbar
    import mbx_pkg::*;
#(
    parameter int N = 4,
    localparam int CORE_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] bus_core,
    input  logic [6:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N-1:0]      irq
);
    typedef struct packed {
        logic [N-1:0][N-1:0]            busy;
        logic [N-1:0][N-1:0]            done;
        logic [N-1:0][N-1:0][MSG_W-1:0] msg;
        logic [N-1:0][N-1:0][EXT_W-1:0] ext;
        logic [N-1:0][N-1:0]            en_busy;
        logic [N-1:0][N-1:0]            en_done;
        logic [DATA_W-1:0]              rdata;
    } st_t;

    st_t st_d, st_q;
    acc_e kind;
    logic [CORE_W-1:0] peer;
    logic self_hit;
    logic [DATA_W-1:0] rd_val;

    mbx_addr_dec #(.N(N)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .peer (peer)
    );

    assign self_hit = (peer == bus_core);

    always_comb begin
        st_d   = st_q;
        rd_val = '0;

        // read mux: pre-write values
        unique case (kind)
            ACC_IN_MSG:  if (!self_hit) rd_val = {st_q.busy[peer][bus_core], st_q.msg[peer][bus_core]};
            ACC_IN_EXT:  if (!self_hit) rd_val = {2'b00, st_q.ext[peer][bus_core]};
            ACC_OUT_MSG: if (!self_hit) rd_val = {st_q.busy[bus_core][peer], st_q.msg[bus_core][peer]};
            ACC_OUT_EXT: if (!self_hit) rd_val = {1'b0, st_q.done[bus_core][peer], st_q.ext[bus_core][peer]};
            ACC_CTL: begin
                rd_val[N-1:0]             = st_q.en_busy[bus_core];
                rd_val[DONE_EN_LSB +: N]  = st_q.en_done[bus_core];
            end
            default: rd_val = '0;
        endcase
        st_d.rdata = bus_rd ? rd_val : '0;

        if (bus_wr) begin
            unique case (kind)
                ACC_OUT_MSG: begin
                    if (!self_hit && bus_wdata[31] && !st_q.busy[bus_core][peer]) begin
                        st_d.busy[bus_core][peer] = 1'b1;
                        st_d.msg[bus_core][peer]  = bus_wdata[MSG_W-1:0];
                    end
                end
                ACC_OUT_EXT: begin
                    if (!self_hit) begin
                        if (!st_q.busy[bus_core][peer])
                            st_d.ext[bus_core][peer] = bus_wdata[EXT_W-1:0];
                        if (bus_wdata[30])
                            st_d.done[bus_core][peer] = 1'b0;
                    end
                end
                ACC_IN_MSG: begin
                    if (!self_hit && bus_wdata[31] && st_q.busy[peer][bus_core]) begin
                        st_d.busy[peer][bus_core] = 1'b0;
                        st_d.done[peer][bus_core] = 1'b1;
                    end
                end
                ACC_CTL: begin
                    for (int j = 0; j < N; j++) begin
                        st_d.en_busy[bus_core][j] = (CORE_W'(j) != bus_core) & bus_wdata[j];
                        st_d.en_done[bus_core][j] = (CORE_W'(j) != bus_core) & bus_wdata[DONE_EN_LSB + j];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mbx_irq #(.N(N)) u_irq (
        .busy    (st_q.busy),
        .done    (st_q.done),
        .en_busy (st_q.en_busy),
        .en_done (st_q.en_done),
        .irq     (irq)
    );

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/mbx_xbar_chk.sv
module mbx_xbar_chk #(
    parameter int N = 4,
    localparam int CORE_W = $clog2(N)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CORE_W-1:0]         bus_core,
    input logic [6:0]                bus_addr,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [31:0]               bus_wdata,
    input logic [31:0]               bus_rdata,
    input logic [N-1:0]              irq,
    input logic [N-1:0][N-1:0]       busy,
    input logic [N-1:0][N-1:0]       done,
    input logic [N-1:0][N-1:0][30:0] msg
);
    localparam logic [2:0] NL = 3'(N);
    logic [CORE_W-1:0] p;
    logic slot_ok, w_out_msg, w_in_msg, w_out_ext;

    assign p         = bus_addr[4 +: CORE_W];
    assign slot_ok   = bus_wr && (bus_addr[6:4] < NL) && (p != bus_core);
    assign w_out_msg = slot_ok && bus_addr[3:0] == 4'h8;
    assign w_in_msg  = slot_ok && bus_addr[3:0] == 4'h0;
    assign w_out_ext = slot_ok && bus_addr[3:0] == 4'hC;

    a_r2_send_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        w_out_msg && bus_wdata[31] && !busy[bus_core][p]
        |=> busy[$past(bus_core)][$past(p)] && msg[$past(bus_core)][$past(p)] == $past(bus_wdata[30:0]));

    a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        w_out_msg && busy[bus_core][p]
        |=> msg[$past(bus_core)][$past(p)] == $past(msg[bus_core][p]));

    a_r5_ack_moves_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        w_in_msg && bus_wdata[31] && busy[p][bus_core]
        |=> !busy[$past(p)][$past(bus_core)] && done[$past(p)][$past(bus_core)]);

    a_r6_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        w_out_ext && bus_wdata[30] |=> !done[$past(bus_core)][$past(p)]);

    a_r10_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'h0);

    for (genvar k = 0; k < N; k++) begin : g_k
        logic [N-1:0] into_k;
        for (genvar j = 0; j < N; j++) begin : g_j
            assign into_k[j] = busy[j][k];
        end
        a_r7_self_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[k][k] && !done[k][k]);
        a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
            irq[k] |-> (|into_k) || (|done[k]));
    end
endmodule

bind mbx_xbar mbx_xbar_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_core  (bus_core),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .busy      (st_q.busy),
    .done      (st_q.done),
    .msg       (st_q.msg)
);

// File: tb/mbx_xbar_bench.sv
module mbx_xbar_bench;
    localparam int N = 4;
    localparam int CW = $clog2(N);
    localparam time T_CLK = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] bus_core = '0;
    logic [6:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq;

    int checks = 0, fails = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(T_CLK/2) clk = ~clk;

    mbx_xbar #(.N(N)) u_mbx_xbar (
        .clk(clk), .rst_n(rst_n), .bus_core(bus_core), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: pops one expectation per completed read
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: read with no expectation, got %h", "R10", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr(input int core, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_core = CW'(core); bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    endtask

    task automatic rd(input int core, input logic [6:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_core = CW'(core); bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic chk_irq(input logic [N-1:0] e, input string t);
        idle();
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rd(0, 7'h18, 32'h0, "R11");
        rd(1, 7'h50, 32'h0, "R11");
        chk_irq(4'b0000, "R11");

        // R8 control with self bits masked
        wr(1, 7'h50, 32'h0000_0303);
        rd(1, 7'h50, 32'h0000_0101, "R8");
        wr(0, 7'h50, 32'h0000_0200);
        rd(0, 7'h50, 32'h0000_0200, "R8");

        // R3 extension visible on both sides
        wr(0, 7'h1C, 32'h3ABC_DE01);
        rd(0, 7'h1C, 32'h3ABC_DE01, "R3");
        rd(1, 7'h04, 32'h3ABC_DE01, "R3");
        chk_irq(4'b0000, "R9");

        // R2 send core0 -> core1
        wr(0, 7'h18, 32'h8123_4567);
        chk_irq(4'b0010, "R9");
        rd(1, 7'h00, 32'h8123_4567, "R2");
        rd(0, 7'h18, 32'h8123_4567, "R2");

        // R4 overwrite while busy, R3 ext frozen while busy
        wr(0, 7'h18, 32'h8765_4321);
        rd(1, 7'h00, 32'h8123_4567, "R4");
        wr(0, 7'h1C, 32'h0000_0055);
        rd(1, 7'h04, 32'h3ABC_DE01, "R3");

        // R5 ack
        wr(1, 7'h00, 32'h0000_0000);
        rd(1, 7'h00, 32'h8123_4567, "R5");
        wr(1, 7'h00, 32'h8000_0000);
        rd(1, 7'h00, 32'h0123_4567, "R5");
        rd(0, 7'h18, 32'h0123_4567, "R5");
        rd(0, 7'h1C, 32'h7ABC_DE01, "R5");
        chk_irq(4'b0001, "R9");

        // R6 done clear (ext also rewritten, channel idle)
        wr(0, 7'h1C, 32'h4000_0000);
        rd(0, 7'h1C, 32'h0000_0000, "R6");
        chk_irq(4'b0000, "R6");

        // R4 write without bit 31
        wr(0, 7'h18, 32'h0000_1111);
        rd(0, 7'h18, 32'h0123_4567, "R4");

        // R7 self slot
        wr(2, 7'h28, 32'h8000_00AA);
        rd(2, 7'h28, 32'h0, "R7");
        rd(2, 7'h20, 32'h0, "R7");
        chk_irq(4'b0000, "R7");

        // R1 out-of-map offset
        rd(2, 7'h44, 32'h0, "R1");

        // R9 disabled source, then enable
        wr(3, 7'h28, 32'h8000_0009);
        chk_irq(4'b0000, "R9");
        rd(2, 7'h30, 32'h8000_0009, "R1");
        wr(2, 7'h50, 32'h0000_0008);
        chk_irq(4'b0100, "R8");

        // R10 idle read data
        idle();
        idle();
        checks++;
        if (bus_rdata !== 32'h0) begin
            fails++;
            $display("FAIL R10: rdata actual %h expected %h", bus_rdata, 32'h0);
        end

        // R11 mid-run reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(4'b0000, "R11");
        rd(2, 7'h30, 32'h0, "R11");
        rd(2, 7'h50, 32'h0, "R11");
        idle();
        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10: pending reads actual %0d expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule